// File: doc/BRIEF.md
# Synthesizer Lock Search Sequencer

This block runs a one-shot calibration search for a radio frequency synthesizer. On a start pulse it walks through a fixed list of oscillator configuration words. For each candidate it programs the synthesizer for the lowest channel over a serial register-write port. It then clears the synthesizer's lock interrupt status, reads it back, and checks it for a lock indication. The first candidate that locks ends the search. If none locks, the block programs a separate fixed fallback ("autocal") setting instead.

The result is kept in a small signed register for later channel changes. After a lock it holds the index one past the candidate that locked. After a fallback it holds -1 and raises an autocal flag. The serial shifter and the status location sit outside the block. Each is reached through a request/done handshake that the block holds until the far side completes it.

Top module: `pll_lock_search`

## Requirements
- R1: Every serial write word is 24 bits: the register address is in bits 23:20 and the 20-bit register value is in bits 19:0. Only addresses 1, 2 and 3 are ever issued.
- R2: A trial writes three words in a fixed order: 0x100047 (synthesizer word 0x47 to register 1), 0x200999 (divide ratio 0x999 to register 2), then register 3 with value 0x40000 ORed with the 16-bit candidate entry.
- R3: After each register-3 write the block performs a status write with data 0xF (sts_we=1, sts_wdata=0xF), and then a status read (sts_we=0).
- R4: After the read handshake, the block samples sts_rdata in the first cycle in which sts_valid is high. A value of zero declares lock; any nonzero value does not.
- R5: The candidate table, in trial order, is 0x664D, 0x666D, 0x665D, 0x667D, 0x6643, 0x6663, 0x6653, 0x6673, 0x664B, 0x666B, 0x665B. Trials start at entry 0 and ascend, and the search stops at the first lock. The final entry is never trialled, so at most 10 trials run.
- R6: When no trial locks, the block then writes 0x106847, 0x200999 and 0x346662, in that order, and performs no status access after them.
- R7: When entry k locks, the result register cfg_idx becomes k+1 and autocal becomes 0.
- R8: When no trial locks, cfg_idx becomes -1 (5'b11111) and autocal becomes 1.
- R9: After reset, cfg_idx is -1, autocal is 0, busy is 0, done is 0, and neither request is asserted.
- R10: A request, together with its word or status operation, is held steady until its done input is seen. A start pulse while busy does not restart or alter the search.
- R11: done is a single-cycle pulse at the end of each search, and cfg_idx and autocal already carry the new result in that cycle. busy falls on the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search when idle |
| wr_req | output | 1 | Serial register write request |
| wr_word | output | 24 | Address and value of the write |
| wr_done | input | 1 | Serial write completed |
| sts_req | output | 1 | Status location access request |
| sts_we | output | 1 | 1 = status write (acknowledge), 0 = read |
| sts_wdata | output | 4 | Data of a status write |
| sts_done | input | 1 | Status access completed |
| sts_valid | input | 1 | Read status data is valid |
| sts_rdata | input | 4 | Lock interrupt status bits |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| cfg_idx | output | 5 | Signed stored configuration index |
| autocal | output | 1 | Fallback setting in use |

## Verification
A trial counter that is off by one shows up at the ports on the third write of the first trial. That register-3 word then carries the wrong candidate, and the result index then disagrees with the read on which the bench reports lock. A sequencer state that skips the acknowledge, or that samples status before sts_valid, changes the order of status operations within one trial. A wrong exit test on the last trial shows up at once: either an extra 11th trial word, or autocal words that appear too early, within a few handshakes of the tenth read.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  localparam int CFG_N      = 11;
  localparam int IDX_W      = 5;
  localparam int WORD_W     = 24;
  localparam int ADDR_W     = 4;
  localparam int VAL_W      = 20;
  localparam int STS_W      = 4;

  localparam logic [VAL_W-1:0] STD_SYN   = 20'h00047;
  localparam logic [VAL_W-1:0] ACAL_SYN  = 20'h06847;
  localparam logic [VAL_W-1:0] DIV_CH1   = 20'h00999;
  localparam logic [VAL_W-1:0] VCO_RSV   = 20'h40000;
  localparam logic [15:0]      ACAL_VCO  = 16'h6662;
  localparam logic [STS_W-1:0] STS_CLEAR = 4'hF;

  typedef enum logic [2:0] {
    S_IDLE, S_SYN, S_DIV, S_VCO, S_ACK, S_RD, S_SAMP, S_FIN
  } seq_state_t;

  function automatic logic [WORD_W-1:0] mk_word(input logic [ADDR_W-1:0] a,
                                                input logic [VAL_W-1:0] v);
    return {a, v};
  endfunction

  function automatic logic [15:0] cfg_entry(input int i);
    case (i)
      0:  return 16'h664D;
      1:  return 16'h666D;
      2:  return 16'h665D;
      3:  return 16'h667D;
      4:  return 16'h6643;
      5:  return 16'h6663;
      6:  return 16'h6653;
      7:  return 16'h6673;
      8:  return 16'h664B;
      9:  return 16'h666B;
      10: return 16'h665B;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/pll_trial_ctr.sv
module pll_trial_ctr #(
  parameter int NUM_CFG = pll_lock_pkg::CFG_N,
  localparam int TW = $clog2(NUM_CFG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [TW-1:0] trial,
  output logic          last
);
  localparam logic [TW-1:0] LAST_T = TW'(NUM_CFG - 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      trial <= '0;
    else if (clr)    trial <= '0;
    else if (inc)    trial <= trial + 1'b1;
  end

  assign last = (trial == LAST_T);

  p_trial_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trial <= LAST_T);
endmodule

// File: rtl/pll_word_gen.sv
module pll_word_gen #(
  parameter int NUM_CFG = pll_lock_pkg::CFG_N,
  localparam int TW = $clog2(NUM_CFG)
) (
  input  logic [1:0]    reg_sel,
  input  logic          acal,
  input  logic [TW-1:0] trial,
  output logic [23:0]   word
);
  import pll_lock_pkg::*;

  logic [15:0] vco_val;
  assign vco_val = acal ? ACAL_VCO : cfg_entry(int'(trial));

  always_comb begin
    case (reg_sel)
      2'd1:    word = mk_word(4'd1, acal ? ACAL_SYN : STD_SYN);
      2'd2:    word = mk_word(4'd2, DIV_CH1);
      2'd3:    word = mk_word(4'd3, VCO_RSV | {4'h0, vco_val});
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/pll_lock_search.sv
module pll_lock_search #(
  parameter int NUM_CFG = pll_lock_pkg::CFG_N,
  localparam int TW = $clog2(NUM_CFG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              wr_req,
  output logic [23:0]       wr_word,
  input  logic              wr_done,
  output logic              sts_req,
  output logic              sts_we,
  output logic [3:0]        sts_wdata,
  input  logic              sts_done,
  input  logic              sts_valid,
  input  logic [3:0]        sts_rdata,
  output logic              busy,
  output logic              done,
  output logic signed [4:0] cfg_idx,
  output logic              autocal
);
  import pll_lock_pkg::*;

  seq_state_t state, nxt;
  logic       acal;
  logic [TW-1:0] trial;
  logic       trial_last;
  logic [1:0] reg_sel;

  // named internal events
  logic go, lock_hit, miss_more, miss_end, vco_written;

  assign go          = (state == S_IDLE) && start;
  assign lock_hit    = (state == S_SAMP) && sts_valid && (sts_rdata == '0);
  assign miss_more   = (state == S_SAMP) && sts_valid && (sts_rdata != '0) && !trial_last;
  assign miss_end    = (state == S_SAMP) && sts_valid && (sts_rdata != '0) && trial_last;
  assign vco_written = (state == S_VCO) && wr_done;

  pll_trial_ctr #(.NUM_CFG(NUM_CFG)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(go), .inc(miss_more),
    .trial(trial), .last(trial_last)
  );

  always_comb begin
    case (state)
      S_SYN:   reg_sel = 2'd1;
      S_DIV:   reg_sel = 2'd2;
      S_VCO:   reg_sel = 2'd3;
      default: reg_sel = 2'd0;
    endcase
  end

  pll_word_gen #(.NUM_CFG(NUM_CFG)) u_gen (
    .reg_sel(reg_sel), .acal(acal), .trial(trial), .word(wr_word)
  );

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (start)    nxt = S_SYN;
      S_SYN:  if (wr_done)  nxt = S_DIV;
      S_DIV:  if (wr_done)  nxt = S_VCO;
      S_VCO:  if (wr_done)  nxt = acal ? S_FIN : S_ACK;
      S_ACK:  if (sts_done) nxt = S_RD;
      S_RD:   if (sts_done) nxt = S_SAMP;
      S_SAMP: begin
        if (lock_hit)                  nxt = S_FIN;
        else if (miss_more || miss_end) nxt = S_SYN;
      end
      S_FIN:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      acal    <= 1'b0;
      cfg_idx <= -5'sd1;
      autocal <= 1'b0;
    end else begin
      state <= nxt;
      if (go) acal <= 1'b0;
      else if (miss_end) acal <= 1'b1;
      if (lock_hit) begin
        cfg_idx <= 5'(trial) + 5'sd1;
        autocal <= 1'b0;
      end else if (vco_written && acal) begin
        cfg_idx <= -5'sd1;
        autocal <= 1'b1;
      end
    end
  end

  assign wr_req    = (state == S_SYN) || (state == S_DIV) || (state == S_VCO);
  assign sts_req   = (state == S_ACK) || (state == S_RD);
  assign sts_we    = (state == S_ACK);
  assign sts_wdata = (state == S_ACK) ? STS_CLEAR : 4'h0;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);

  p_addr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_word[23:20] >= 4'd1 && wr_word[23:20] <= 4'd3));
  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_done |=> wr_req && $stable(wr_word));
  p_sts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sts_req && !sts_done |=> sts_req && $stable(sts_we));
  p_ack_then_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sts_req && sts_we && sts_done |=> sts_req && !sts_we);
  p_start_needed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  p_lock_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !autocal |-> (cfg_idx >= 5'sd1 && cfg_idx <= 5'(NUM_CFG - 1)));
  p_acal_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && autocal |-> cfg_idx == -5'sd1);
  p_one_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && sts_req));
endmodule

// File: tb/sim_pll_lock_search.sv
module sim_pll_lock_search;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic wr_req, wr_done = 1'b0;
  logic [23:0] wr_word;
  logic sts_req, sts_we, sts_done = 1'b0, sts_valid = 1'b0;
  logic [3:0] sts_wdata, sts_rdata = 4'h0;
  logic busy, done, autocal;
  logic signed [4:0] cfg_idx;

  int total = 0, bad = 0;
  int lock_at = -1;
  logic [23:0] wlog [0:63];
  int wn = 0;
  logic slog [0:63];
  int sn = 0, rd_n = 0;
  bit ack_bad = 0, rd_pend = 0;

  always #(PERIOD/2) clk = ~clk;

  pll_lock_search u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .wr_req(wr_req), .wr_word(wr_word), .wr_done(wr_done),
    .sts_req(sts_req), .sts_we(sts_we), .sts_wdata(sts_wdata),
    .sts_done(sts_done), .sts_valid(sts_valid), .sts_rdata(sts_rdata),
    .busy(busy), .done(done), .cfg_idx(cfg_idx), .autocal(autocal)
  );

  function automatic logic [15:0] tab(input int i);
    logic [15:0] t [0:10] = '{16'h664D,16'h666D,16'h665D,16'h667D,16'h6643,
      16'h6663,16'h6653,16'h6673,16'h664B,16'h666B,16'h665B};
    return t[i];
  endfunction

  // far-side responder for the serial port and status location
  initial forever begin
    @(negedge clk);
    if (wr_done) wr_done = 1'b0;
    else if (wr_req) begin
      if (wn < 64) wlog[wn] = wr_word;
      wn++;
      wr_done = 1'b1;
    end
    if (sts_valid) sts_valid = 1'b0;
    if (sts_done) begin
      sts_done = 1'b0;
      if (rd_pend) begin
        sts_valid = 1'b1;
        sts_rdata = (rd_n == lock_at) ? 4'h0 : 4'h5;
        rd_n++;
        rd_pend = 0;
      end
    end else if (sts_req) begin
      if (sn < 64) slog[sn] = sts_we;
      sn++;
      if (sts_we && sts_wdata != 4'hF) ack_bad = 1;
      if (!sts_we) rd_pend = 1;
      sts_done = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_reset();
    @(negedge clk);
    chk(cfg_idx == -5'sd1, "R9 cfg_idx", cfg_idx, 5'h1F);
    chk(!autocal && !busy && !done, "R9 flags", {autocal, busy, done}, 0);
    chk(!wr_req && !sts_req, "R9 requests", {wr_req, sts_req}, 0);
  endtask

  // one search; la = read number that reports lock (-1 or >=10 means none)
  task automatic run_search(input int la, input bit poke);
    int ntr, exp_n, cyc;
    bit locked;
    lock_at = la; wn = 0; sn = 0; rd_n = 0; ack_bad = 0;
    locked = (la >= 0 && la < 10);
    ntr = locked ? la + 1 : 10;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy, "R10 busy after start", busy, 1);
    if (poke) begin
      repeat (7) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(cyc < 5000, "R11 done seen", cyc, 0);
    exp_n = 3 * ntr + (locked ? 0 : 3);
    chk(wn == exp_n, "R5 word count", wn, exp_n);
    for (int t = 0; t < ntr && 3*t+2 < wn; t++) begin
      chk(wlog[3*t]   == 24'h100047, "R2 synth word", wlog[3*t], 24'h100047);
      chk(wlog[3*t+1] == 24'h200999, "R2 divide word", wlog[3*t+1], 24'h200999);
      chk(wlog[3*t+2] == {4'h3, 4'h4, tab(t)}, "R5 candidate word",
          wlog[3*t+2], {4'h3, 4'h4, tab(t)});
      chk(wlog[3*t+2][23:20] == 4'd3 && wlog[3*t][23:20] == 4'd1, "R1 address field",
          {wlog[3*t][23:20], wlog[3*t+2][23:20]}, 8'h13);
    end
    if (!locked && wn == exp_n) begin
      chk(wlog[30] == 24'h106847, "R6 autocal synth", wlog[30], 24'h106847);
      chk(wlog[31] == 24'h200999, "R6 autocal divide", wlog[31], 24'h200999);
      chk(wlog[32] == 24'h346662, "R6 autocal vco", wlog[32], 24'h346662);
    end
    chk(sn == 2 * ntr, "R3 status op count", sn, 2 * ntr);
    for (int k = 0; k < sn && k < 64; k++)
      chk(slog[k] == ((k % 2) == 0), "R3 ack then read", slog[k], (k % 2) == 0);
    chk(!ack_bad, "R3 ack data 0xF", ack_bad, 0);
    chk(rd_n == ntr, "R4 reads sampled", rd_n, ntr);
    if (locked) begin
      chk(cfg_idx == 5'(la + 1), "R7 index", cfg_idx, la + 1);
      chk(!autocal, "R7 autocal clear", autocal, 0);
    end else begin
      chk(cfg_idx == -5'sd1, "R8 index", cfg_idx, 5'h1F);
      chk(autocal, "R8 autocal set", autocal, 1);
    end
    @(negedge clk);
    chk(!done && !busy, "R11 single pulse", {done, busy}, 0);
    repeat (3) @(negedge clk);
    chk(!wr_req && !sts_req && !busy, "R10 no restart", {wr_req, sts_req, busy}, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    check_reset();
    run_search(0, 1'b0);
    run_search(3, 1'b1);
    run_search(-1, 1'b0);
    run_search(9, 1'b0);
    run_search(10, 1'b1);
    run_search(5, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule